// File: doc/BRIEF.md
# Status-Flag Arithmetic and Logic Unit

This block is the integer execution stage of a small processor datapath. Each clock cycle it takes one operation code, a width select (byte or word), a destination operand, a source operand and a shift count. It registers a result and a 16-bit flag word. The flag word holds six condition flags (carry, parity, half-carry, zero, sign, overflow) and three control flags (trap, interrupt enable, direction). Each operation class has its own rule for which flags it writes. The rest of the flags keep their values, so the flag word always reflects the last operation that was allowed to change each bit.

The arithmetic group covers add, add with carry, subtract, subtract with borrow, compare, increment, decrement and negate. The logic group covers AND, OR, XOR and NOT. Four shift and rotate kinds take a count from 0 to 31. A set of flag-only operations sets, clears or complements the carry and direction flags, and sets or clears the trap and interrupt-enable flags. Single-operand operations read the destination operand.

Top module: `flag_alu`

## Requirements
- R1: The operation code is 5 bits: 0 no-op, 1 add, 2 add-with-carry, 3 subtract, 4 subtract-with-borrow, 5 compare, 6 increment, 7 decrement, 8 negate, 9 AND, 10 OR, 11 XOR, 12 NOT, 13 shift left, 14 shift right, 15 rotate left, 16 rotate right, 17 set CF, 18 clear CF, 19 complement CF, 20 set DF, 21 clear DF, 22 complement DF, 23 set IF, 24 clear IF, 25 set TF, 26 clear TF. Codes 27 to 31 act as no-op. With `wide`=0 only the low 8 bits of each operand are used, and a written result has its upper byte at zero.
- R2: The flag word places CF at bit 0, PF at bit 2, AF at bit 4, ZF at bit 6, SF at bit 7, TF at bit 8, IF at bit 9, DF at bit 10 and OF at bit 11. All other bits read 0. Reset clears both the result and the flag word.
- R3: Add, add-with-carry, subtract, subtract-with-borrow and negate (0 minus destination) write the result and set all six condition flags. CF is the carry out, or the borrow for the subtracting forms. AF is the carry or borrow between bits 3 and 4. OF is signed overflow at the selected width. ZF is set for a zero result. SF is the result MSB. PF is 1 when the low result byte has an even count of ones. An 8-bit 7Fh plus 1 gives 80h with CF=0, PF=0, AF=1, ZF=0, SF=1, OF=1.
- R4: Compare computes destination minus source and sets the six condition flags as subtract does. The result output keeps its previous value.
- R5: Increment and decrement write the result and set AF, OF, PF, SF and ZF. CF is left unchanged.
- R6: AND, OR and XOR write the result, clear CF and OF, update PF, SF and ZF, and keep AF. NOT writes the bitwise complement and changes no flag.
- R7: Shift left fills with zeros, and CF is the last bit moved out of the MSB. OF is then the result MSB XOR CF. Shift right fills with zeros, and CF is the last bit moved out of the LSB. OF is then the MSB of the original operand. Both shifts update PF, SF and ZF and keep AF. A count at or beyond the width gives a zero result.
- R8: Rotate left and rotate right move bits around within the selected width, and CF takes the bit that last wrapped (result LSB for left, result MSB for right). OF is the result MSB XOR CF for left, and the XOR of the two top result bits for right. PF, SF, ZF and AF are kept.
- R9: A shift or rotate with a count of zero changes neither the result nor any flag.
- R10: Codes 17 to 22 set, clear or complement CF or DF and change nothing else. DF changes through no other code.
- R11: TF and IF change only through codes 23 to 26. A no-op code changes neither output.
- R12: The result and flags of an operation presented before a rising clock edge appear right after that edge. Carry-in and borrow-in use the flag word as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 5 | Operation code (R1) |
| wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| dst | input | 16 | Destination / single operand |
| src | input | 16 | Source operand |
| cnt | input | 5 | Shift or rotate count |
| result | output | 16 | Registered result |
| flags | output | 16 | Registered flag word |

## Verification
A corrupted flag register shows up at the ports in two ways. It appears directly on `flags` one cycle later, and it reaches `result` on the next add-with-carry or subtract-with-borrow, which read the stored CF. A flag wrongly written by an operation that should keep it (CF on increment, AF on logic operations, TF/IF/DF on arithmetic) stays visible until an operation that legally rewrites that bit. Because of this, the random mix interleaves flag-keeping operations with carry-consuming ones, so a stale or clobbered bit reaches a compare within a few cycles.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    localparam int DW    = 16;
    localparam int HW    = DW / 2;
    localparam int CW    = 5;
    localparam int OPW   = 5;

    localparam int F_CF = 0;
    localparam int F_PF = 2;
    localparam int F_AF = 4;
    localparam int F_ZF = 6;
    localparam int F_SF = 7;
    localparam int F_TF = 8;
    localparam int F_IF = 9;
    localparam int F_DF = 10;
    localparam int F_OF = 11;

    localparam logic [DW-1:0] USED_MASK =
        DW'((1 << F_CF) | (1 << F_PF) | (1 << F_AF) | (1 << F_ZF) | (1 << F_SF) |
            (1 << F_TF) | (1 << F_IF) | (1 << F_DF) | (1 << F_OF));

    typedef enum logic [OPW-1:0] {
        OP_NOP = 5'd0,  OP_ADD = 5'd1,  OP_ADC = 5'd2,  OP_SUB = 5'd3,
        OP_SBB = 5'd4,  OP_CMP = 5'd5,  OP_INC = 5'd6,  OP_DEC = 5'd7,
        OP_NEG = 5'd8,  OP_AND = 5'd9,  OP_OR  = 5'd10, OP_XOR = 5'd11,
        OP_NOT = 5'd12, OP_SHL = 5'd13, OP_SHR = 5'd14, OP_ROL = 5'd15,
        OP_ROR = 5'd16, OP_STC = 5'd17, OP_CLC = 5'd18, OP_CMC = 5'd19,
        OP_STD = 5'd20, OP_CLD = 5'd21, OP_CMD = 5'd22, OP_STI = 5'd23,
        OP_CLI = 5'd24, OP_STT = 5'd25, OP_CLT = 5'd26
    } alu_op_e;

    typedef enum logic [1:0] {
        SK_SHL = 2'd0, SK_SHR = 2'd1, SK_ROL = 2'd2, SK_ROR = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          cf;
        logic          af;
        logic          of;
    } arith_out_t;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          cf;
        logic          of;
    } shift_out_t;

    function automatic logic [DW-1:0] width_mask(input logic wide);
        return wide ? {DW{1'b1}} : {{(DW-HW){1'b0}}, {HW{1'b1}}};
    endfunction

    function automatic logic msb_of(input logic [DW-1:0] v, input logic wide);
        return wide ? v[DW-1] : v[HW-1];
    endfunction

    function automatic logic [DW-1:0] put_szp(input logic [DW-1:0] fl,
                                             input logic [DW-1:0] v,
                                             input logic wide);
        logic [DW-1:0] o;
        o       = fl;
        o[F_ZF] = ((v & width_mask(wide)) == '0);
        o[F_SF] = msb_of(v, wide);
        o[F_PF] = ~^v[7:0];
        return o;
    endfunction

endpackage

// File: rtl/flag_alu_addsub.sv
module flag_alu_addsub
    import flag_alu_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    input  logic         wide,
    output arith_out_t   out
);
    localparam int H = W / 2;

    logic [W-1:0] mask;
    logic [W-1:0] b_eff;
    logic         c0;
    logic [W:0]   sum;
    logic         carry;
    logic         half;
    logic [W-1:0] res;

    always_comb begin
        mask  = width_mask(wide);
        b_eff = sub ? (~b & mask) : (b & mask);
        c0    = cin ^ sub;
        sum   = {1'b0, a & mask} + {1'b0, b_eff} + {{W{1'b0}}, c0};
        carry = wide ? sum[W] : sum[H];
        half  = a[4] ^ b_eff[4] ^ sum[4];
        res   = sum[W-1:0] & mask;
        out.res = res;
        out.cf  = carry ^ sub;
        out.af  = half ^ sub;
        out.of  = (msb_of(a, wide) == msb_of(b_eff, wide)) &&
                  (msb_of(res, wide) != msb_of(a, wide));
    end
endmodule

// File: rtl/flag_alu_shift.sv
module flag_alu_shift
    import flag_alu_pkg::*;
#(
    parameter int W  = DW,
    parameter int CN = CW
) (
    input  shift_kind_e   kind,
    input  logic          wide,
    input  logic [W-1:0]  opnd,
    input  logic [CN-1:0] cnt,
    output shift_out_t    out
);
    localparam int H  = W / 2;
    localparam int KB = $clog2(H);
    localparam int KW = $clog2(W);

    logic [W:0]    shl_ext;
    logic [W:0]    shr_ext;
    logic [H-1:0]  ob;
    logic [H-1:0]  rol_b, ror_b;
    logic [W-1:0]  rol_w, ror_w;
    logic [KB-1:0] kb;
    logic [KW-1:0] kw;
    logic [W-1:0]  r;
    logic          c;
    logic          o;

    always_comb begin
        shl_ext = {1'b0, opnd} << cnt;
        shr_ext = {opnd, 1'b0} >> cnt;
        ob      = opnd[H-1:0];
        kb      = cnt[KB-1:0];
        kw      = cnt[KW-1:0];
        rol_b   = (ob << kb) | (ob >> (H - int'(kb)));
        ror_b   = (ob >> kb) | (ob << (H - int'(kb)));
        rol_w   = (opnd << kw) | (opnd >> (W - int'(kw)));
        ror_w   = (opnd >> kw) | (opnd << (W - int'(kw)));
        r = '0;
        c = 1'b0;
        o = 1'b0;
        case (kind)
            SK_SHL: begin
                r = shl_ext[W-1:0];
                c = wide ? shl_ext[W] : shl_ext[H];
                o = msb_of(r, wide) ^ c;
            end
            SK_SHR: begin
                r = shr_ext[W:1];
                c = shr_ext[0];
                o = msb_of(opnd, wide);
            end
            SK_ROL: begin
                r = wide ? rol_w : {{(W-H){1'b0}}, rol_b};
                c = r[0];
                o = msb_of(r, wide) ^ c;
            end
            default: begin
                r = wide ? ror_w : {{(W-H){1'b0}}, ror_b};
                c = msb_of(r, wide);
                o = c ^ (wide ? r[W-2] : r[H-2]);
            end
        endcase
        out.res = r & width_mask(wide);
        out.cf  = c;
        out.of  = o;
    end
endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
    import flag_alu_pkg::*;
#(
    parameter int W = DW
) (
    input  alu_op_e      op,
    input  logic         wide,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = ~a;
        endcase
        res = res & width_mask(wide);
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [OPW-1:0] op_code,
    input  logic          wide,
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] src,
    input  logic [CW-1:0] cnt,
    output logic [DW-1:0] result,
    output logic [DW-1:0] flags
);
    alu_op_e       op;
    logic [DW-1:0] mask;
    logic [DW-1:0] dm, sm;
    logic [DW-1:0] ar_a, ar_b;
    logic          ar_cin, ar_sub;
    arith_out_t    ar;
    logic [DW-1:0] lg_res;
    shift_kind_e   sk;
    shift_out_t    sh;
    logic [DW-1:0] res_q, fl_q;
    logic [DW-1:0] res_n, fl_n;

    assign op   = alu_op_e'(op_code);
    assign mask = width_mask(wide);
    assign dm   = dst & mask;
    assign sm   = src & mask;

    always_comb begin
        ar_a   = dm;
        ar_b   = sm;
        ar_cin = 1'b0;
        ar_sub = 1'b0;
        case (op)
            OP_ADC:         ar_cin = fl_q[F_CF];
            OP_SUB, OP_CMP: ar_sub = 1'b1;
            OP_SBB: begin
                ar_sub = 1'b1;
                ar_cin = fl_q[F_CF];
            end
            OP_INC:         ar_b = DW'(1);
            OP_DEC: begin
                ar_b   = DW'(1);
                ar_sub = 1'b1;
            end
            OP_NEG: begin
                ar_a   = '0;
                ar_b   = dm;
                ar_sub = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        case (op)
            OP_SHL:  sk = SK_SHL;
            OP_SHR:  sk = SK_SHR;
            OP_ROL:  sk = SK_ROL;
            default: sk = SK_ROR;
        endcase
    end

    flag_alu_addsub #(.W(DW)) u_addsub (
        .a(ar_a), .b(ar_b), .cin(ar_cin), .sub(ar_sub), .wide(wide), .out(ar)
    );

    flag_alu_logic #(.W(DW)) u_logic (
        .op(op), .wide(wide), .a(dm), .b(sm), .res(lg_res)
    );

    flag_alu_shift #(.W(DW), .CN(CW)) u_shift (
        .kind(sk), .wide(wide), .opnd(dm), .cnt(cnt), .out(sh)
    );

    always_comb begin
        res_n = res_q;
        fl_n  = fl_q;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_NEG, OP_CMP: begin
                if (op != OP_CMP) res_n = ar.res;
                fl_n       = put_szp(fl_q, ar.res, wide);
                fl_n[F_CF] = ar.cf;
                fl_n[F_AF] = ar.af;
                fl_n[F_OF] = ar.of;
            end
            OP_INC, OP_DEC: begin
                res_n      = ar.res;
                fl_n       = put_szp(fl_q, ar.res, wide);
                fl_n[F_AF] = ar.af;
                fl_n[F_OF] = ar.of;
            end
            OP_AND, OP_OR, OP_XOR: begin
                res_n      = lg_res;
                fl_n       = put_szp(fl_q, lg_res, wide);
                fl_n[F_CF] = 1'b0;
                fl_n[F_OF] = 1'b0;
            end
            OP_NOT: res_n = lg_res;
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                if (cnt != '0) begin
                    res_n = sh.res;
                    if (op == OP_SHL || op == OP_SHR)
                        fl_n = put_szp(fl_q, sh.res, wide);
                    fl_n[F_CF] = sh.cf;
                    fl_n[F_OF] = sh.of;
                end
            end
            OP_STC: fl_n[F_CF] = 1'b1;
            OP_CLC: fl_n[F_CF] = 1'b0;
            OP_CMC: fl_n[F_CF] = ~fl_q[F_CF];
            OP_STD: fl_n[F_DF] = 1'b1;
            OP_CLD: fl_n[F_DF] = 1'b0;
            OP_CMD: fl_n[F_DF] = ~fl_q[F_DF];
            OP_STI: fl_n[F_IF] = 1'b1;
            OP_CLI: fl_n[F_IF] = 1'b0;
            OP_STT: fl_n[F_TF] = 1'b1;
            OP_CLT: fl_n[F_TF] = 1'b0;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            fl_q  <= '0;
        end else begin
            res_q <= res_n;
            fl_q  <= fl_n;
        end
    end

    assign result = res_q;
    assign flags  = fl_q;

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
    import flag_alu_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [OPW-1:0] op_code,
    input logic           wide,
    input logic [DW-1:0]  dst,
    input logic [DW-1:0]  src,
    input logic [CW-1:0]  cnt,
    input logic [DW-1:0]  result,
    input logic [DW-1:0]  flags
);
    logic is_shift, is_tfif_op, is_df_op, is_byte_res;

    assign is_shift    = (op_code == OP_SHL) || (op_code == OP_SHR) ||
                         (op_code == OP_ROL) || (op_code == OP_ROR);
    assign is_tfif_op  = (op_code >= OP_STI) && (op_code <= OP_CLT);
    assign is_df_op    = (op_code >= OP_STD) && (op_code <= OP_CMD);
    assign is_byte_res = !wide && (op_code >= OP_ADD) && (op_code <= OP_NOT) &&
                         (op_code != OP_CMP);

    // R2
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (flags & ~USED_MASK) == '0);

    // R5
    incdec_keeps_cf_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_INC || op_code == OP_DEC) |=> flags[F_CF] == $past(flags[F_CF]));

    // R6
    logic_clears_cf_of_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR)
        |=> (!flags[F_CF] && !flags[F_OF]));

    // R4
    cmp_holds_result_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_CMP) |=> $stable(result));

    // R9
    zero_count_chk: assert property (@(posedge clk) disable iff (rst)
        (is_shift && cnt == '0) |=> ($stable(result) && $stable(flags)));

    // R11
    tf_if_only_explicit_chk: assert property (@(posedge clk) disable iff (rst)
        !is_tfif_op |=> flags[F_IF:F_TF] == $past(flags[F_IF:F_TF]));

    // R10
    df_only_explicit_chk: assert property (@(posedge clk) disable iff (rst)
        !is_df_op |=> flags[F_DF] == $past(flags[F_DF]));

    // R10
    stc_sets_cf_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_STC) |=> flags[F_CF]);

    // R1
    byte_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        is_byte_res |=> result[DW-1:HW] == '0);

    // R3
    add_zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_ADD) |=> flags[F_ZF] == (result == '0));

endmodule

bind flag_alu flag_alu_chk u_chk (.*);

// File: tb/tb_flag_alu.sv
module tb_flag_alu;
    import flag_alu_pkg::*;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [4:0]    op_code = 5'd0;
    logic          wide = 1'b0;
    logic [15:0]   dst = '0, src = '0;
    logic [4:0]    cnt = '0;
    logic [15:0]   result, flags;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] m_res = '0, m_fl = '0;

    always #2 clk = ~clk;

    flag_alu dut (.clk(clk), .rst(rst), .op_code(op_code), .wide(wide),
                  .dst(dst), .src(src), .cnt(cnt), .result(result), .flags(flags));

    function automatic logic [15:0] szp(input logic [15:0] f, input int v, input int w);
        logic [15:0] o = f;
        o[6] = (v == 0);
        o[7] = (v >> (w - 1)) & 1;
        o[2] = ~^(8'(v));
        return o;
    endfunction

    task automatic model(input int op, input bit wd, input int ai, input int bi, input int c);
        int w = wd ? 16 : 8;
        int mask = (1 << w) - 1;
        int a = ai & mask;
        int b = bi & mask;
        int s, r, cin;
        bit cf;
        if (op == 8) begin b = a; a = 0; end
        if (op == 6 || op == 7) b = 1;
        case (op)
            1, 2, 6: begin
                cin = (op == 2) ? int'(m_fl[0]) : 0;
                s = a + b + cin;
                r = s & mask;
                if (op != 6) m_fl[0] = (s >> w) & 1;
                m_fl[4] = ((a & 15) + (b & 15) + cin) > 15;
                m_fl[11] = (((a >> (w-1)) & 1) == ((b >> (w-1)) & 1)) &&
                           (((r >> (w-1)) & 1) != ((a >> (w-1)) & 1));
                m_fl = szp(m_fl, r, w);
                m_res = 16'(r);
            end
            3, 4, 5, 7, 8: begin
                cin = (op == 4) ? int'(m_fl[0]) : 0;
                s = a - b - cin;
                r = s & mask;
                if (op != 7) m_fl[0] = (s < 0);
                m_fl[4] = ((a & 15) - (b & 15) - cin) < 0;
                m_fl[11] = (((a >> (w-1)) & 1) != ((b >> (w-1)) & 1)) &&
                           (((r >> (w-1)) & 1) != ((a >> (w-1)) & 1));
                m_fl = szp(m_fl, r, w);
                if (op != 5) m_res = 16'(r);
            end
            9, 10, 11: begin
                r = (op == 9) ? (a & b) : (op == 10) ? (a | b) : (a ^ b);
                m_fl[0] = 0; m_fl[11] = 0;
                m_fl = szp(m_fl, r, w);
                m_res = 16'(r);
            end
            12: m_res = 16'(~a & mask);
            13, 14, 15, 16: if (c != 0) begin
                r = a; cf = 0;
                for (int i = 0; i < c; i++) begin
                    case (op)
                        13: begin cf = (r >> (w-1)) & 1; r = (r << 1) & mask; end
                        14: begin cf = r & 1; r = r >> 1; end
                        15: begin cf = (r >> (w-1)) & 1; r = ((r << 1) | int'(cf)) & mask; end
                        default: begin cf = r & 1; r = (r >> 1) | (int'(cf) << (w-1)); end
                    endcase
                end
                m_fl[0] = cf;
                case (op)
                    13, 15: m_fl[11] = ((r >> (w-1)) & 1) ^ int'(cf);
                    14: m_fl[11] = (a >> (w-1)) & 1;
                    default: m_fl[11] = ((r >> (w-1)) ^ (r >> (w-2))) & 1;
                endcase
                if (op == 13 || op == 14) m_fl = szp(m_fl, r, w);
                m_res = 16'(r);
            end
            17: m_fl[0] = 1;  18: m_fl[0] = 0;  19: m_fl[0] = ~m_fl[0];
            20: m_fl[10] = 1; 21: m_fl[10] = 0; 22: m_fl[10] = ~m_fl[10];
            23: m_fl[9] = 1;  24: m_fl[9] = 0;
            25: m_fl[8] = 1;  26: m_fl[8] = 0;
            default: ;
        endcase
    endtask

    task automatic check(input string tag, input logic [15:0] er, input logic [15:0] ef);
        checks++;
        if (result !== er || flags !== ef) begin
            errors++;
            $display("FAIL %s: result=%h flags=%h expected result=%h flags=%h",
                     tag, result, flags, er, ef);
        end
    endtask

    task automatic run(input int op, input bit wd, input int a, input int b,
                       input int c, input string tag);
        model(op, wd, a, b, c);
        op_code = 5'(op); wide = wd; dst = 16'(a); src = 16'(b); cnt = 5'(c);
        @(posedge clk);
        #1;
        check(tag, m_res, m_fl);
        op_code = 5'd0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: result=%h flags=%h expected completion", result, flags);
        finish_up();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1;
        check("R2 reset state", 16'h0000, 16'h0000);
        rst = 0;
        // R3 byte 7Fh + 1 with fixed expected value
        run(1, 0, 16'h007F, 16'h0001, 0, "R3 add 7F+1");
        check("R3 add 7F+1 fixed", 16'h0080, 16'h0890);
        // R12 and R3: borrow then subtract-with-borrow uses it
        run(3, 0, 16'h0010, 16'h0020, 0, "R3 sub borrow");
        run(4, 1, 16'h1000, 16'h0001, 0, "R12 sbb uses stored CF");
        run(1, 1, 16'h7FFF, 16'h0001, 0, "R3 word overflow");
        run(8, 0, 16'h0000, 0, 0, "R3 negate zero");
        run(8, 1, 16'h8000, 0, 0, "R3 negate min");
        // R5
        run(17, 0, 0, 0, 0, "R10 set CF");
        run(6, 0, 16'h00FF, 0, 0, "R5 inc keeps CF");
        run(7, 1, 16'h0000, 0, 0, "R5 dec keeps CF");
        // R4
        run(5, 1, 16'h1234, 16'h1234, 0, "R4 compare equal");
        // R6
        run(9, 1, 16'hF0F0, 16'h0F0F, 0, "R6 and zero");
        run(12, 0, 16'h00A5, 0, 0, "R6 not no flags");
        // R7 R8 R9
        run(13, 0, 16'h0081, 0, 1, "R7 shl one");
        run(13, 0, 16'h0081, 0, 8, "R7 shl full width");
        run(14, 1, 16'h8001, 0, 17, "R7 shr beyond width");
        run(15, 0, 16'h0081, 0, 9, "R8 rol wrap");
        run(16, 1, 16'h0001, 0, 1, "R8 ror one");
        run(13, 1, 16'hFFFF, 0, 0, "R9 zero count");
        run(16, 0, 16'h0055, 0, 0, "R9 zero count rotate");
        // R10 R11
        run(20, 0, 0, 0, 0, "R10 set DF");
        run(22, 0, 0, 0, 0, "R10 complement DF");
        run(19, 0, 0, 0, 0, "R10 complement CF");
        run(23, 0, 0, 0, 0, "R11 set IF");
        run(25, 0, 0, 0, 0, "R11 set TF");
        run(29, 1, 16'hFFFF, 16'hFFFF, 3, "R11 undefined code no-op");
        run(0, 1, 16'hFFFF, 16'hFFFF, 3, "R1 no-op");
        run(2, 0, 16'hABFF, 16'hCD01, 0, "R1 byte ignores upper bits");
        for (int i = 0; i < 3000; i++) begin
            int op = $urandom_range(0, 31);
            run(op, 1'($urandom), int'($urandom & 16'hFFFF),
                int'($urandom & 16'hFFFF), $urandom_range(0, 31), "R3 R7 R8 random mix");
        end
        finish_up();
    end
endmodule